// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter

This block decides which of four DMA channels may drive the local bus. Each channel raises a request line; the arbiter answers with a one-hot grant. The arbiter has two selectable policies. In round-robin mode, the search for the next owner starts at the channel after the one granted most recently, so every requesting channel gets an equal share of the bus. In fixed mode, a 2-bit field chooses one of four constant orderings.

Once a channel owns the bus, it keeps the grant for as long as it reports a well-formed burst in progress. If the owner does not report a burst, the grant lasts a single cycle. Every release is followed by a fixed two-cycle gap with no grant, which stands for the crossing between the two clock domains. After the gap the arbiter resolves the next request.

Top module: `dma_bus_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle.
- R2: While `rst_n` is low, `gnt` is all zero. After reset, the first round-robin decision searches from channel 0 upward.
- R3: A grant appears on the clock edge that follows the decision cycle. It goes only to a channel whose `req` bit was high in that decision cycle.
- R4: When `mode_rr` is 0, `prio_sel` = n makes channel n the highest priority. The other channels follow in the order n+1, n+2, n+3, taken modulo 4.
- R5: When `mode_rr` is 1, the search starts at the channel after the most recently granted channel, in either mode, and wraps modulo 4.
- R6: While the granted channel i has `burst[i]` high in a granted cycle, the same grant is kept in the next cycle. The state of the other requests makes no difference.
- R7: If the granted channel i has `burst[i]` low in a granted cycle, `gnt` is all zero in the next cycle.
- R8: After a release, `gnt` stays all zero for exactly two cycles. A new decision is made in the second of those cycles, so a pending request is granted in the cycle after it.
- R9: With no request pending, all grants stay low and the round-robin position does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Request line of each channel |
| burst | input | 4 | Per-channel flag: the burst is continuing |
| mode_rr | input | 1 | 1 = round-robin, 0 = fixed priority |
| prio_sel | input | 2 | Highest-priority channel in fixed mode |
| gnt | output | 4 | One-hot grant |

## Verification
A table of single decisions runs the round-robin policy with all four channels requesting, so that the rotation shows up. It then uses sparse request patterns, which tell wrap-around apart from a plain lowest-index choice. Each of the four fixed orderings is tried with the programmed top channel idle, which shows whether the order continues upward modulo 4 rather than falling back to channel 0. Directed sequences hold a burst while other channels request and then drop it, measuring the grant's hold, its release and the exact width of the gap. A long idle stretch followed by a full request shows that the round-robin position did not move.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_OWN  = 2'd1,
    ARB_GAP  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_arb_picker.sv
// Rotating-priority picker: the first requester found at or after 'start'.
module dma_arb_picker #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [IDX_W-1:0]  start,
  output logic              hit,
  output logic [IDX_W-1:0]  pick
);
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    // walk from the farthest candidate down, so the nearest one wins
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      logic [IDX_W-1:0] cand;
      cand = IDX_W'((int'(start) + k) % NUM_CH);
      if (req[cand]) begin
        hit  = 1'b1;
        pick = cand;
      end
    end
  end
endmodule

// File: rtl/dma_arb_rr_ptr.sv
// Holds the most recently granted channel and offers the next start point.
module dma_arb_rr_ptr #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  output logic [IDX_W-1:0] rr_start
);
  localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NUM_CH - 1);

  logic [IDX_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= LAST_CH;
    else if (upd_en) last_q <= upd_idx;
  end

  always_comb begin
    if (last_q == LAST_CH) rr_start = '0;
    else                   rr_start = last_q + IDX_W'(1);
  end
endmodule

// File: rtl/dma_arb_ctrl.sv
// Ownership state machine: decide, hold during a burst, then a fixed gap.
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int GAP_CYCLES = 2,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(GAP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] burst,
  input  logic              win_hit,
  input  logic [IDX_W-1:0]  win_idx,
  output logic              take,
  output logic [NUM_CH-1:0] gnt
);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

  arb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [IDX_W-1:0] own_q;
  logic             decide;

  assign decide = (state_q == ARB_IDLE) ||
                  ((state_q == ARB_GAP) && (cnt_q == GAP_LAST));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    take    = 1'b0;
    case (state_q)
      ARB_OWN: begin
        if (!burst[own_q]) begin
          state_d = ARB_GAP;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ARB_IDLE, ARB_GAP: begin
        if (decide) begin
          if (win_hit) begin
            state_d = ARB_OWN;
            take    = 1'b1;
          end else begin
            state_d = ARB_IDLE;
          end
        end else begin
          cnt_d  = cnt_q + CNT_W'(1);
          cnt_en = 1'b1;
        end
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    own_q <= '0;
    else if (take) own_q <= win_idx;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_gnt
    assign gnt[i] = (state_q == ARB_OWN) && (own_q == IDX_W'(i));
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NUM_CH     = 4,
  parameter int GAP_CYCLES = 2,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] burst,
  input  logic              mode_rr,
  input  logic [IDX_W-1:0]  prio_sel,
  output logic [NUM_CH-1:0] gnt
);
  logic [IDX_W-1:0] rr_start;
  logic [IDX_W-1:0] search_start;
  logic             win_hit;
  logic [IDX_W-1:0] win_idx;
  logic             take;

  assign search_start = mode_rr ? rr_start : prio_sel;

  dma_arb_picker #(.NUM_CH(NUM_CH)) u_pick (
    .req   (req),
    .start (search_start),
    .hit   (win_hit),
    .pick  (win_idx)
  );

  dma_arb_rr_ptr #(.NUM_CH(NUM_CH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (take),
    .upd_idx  (win_idx),
    .rr_start (rr_start)
  );

  dma_arb_ctrl #(.NUM_CH(NUM_CH), .GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .burst   (burst),
    .win_hit (win_hit),
    .win_idx (win_idx),
    .take    (take),
    .gnt     (gnt)
  );
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req,
  input logic [NUM_CH-1:0] burst,
  input logic [NUM_CH-1:0] gnt
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r3_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(gnt) == '0) && (gnt != '0)) |-> ((gnt & $past(req)) != '0));

  a_r6_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & burst)) |=> (gnt == $past(gnt)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !(|(gnt & burst))) |=> (gnt == '0));

  a_r8_gap_second: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !(|(gnt & burst))) |=> ##1 (gnt == '0));

  a_r9_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt == '0) && (req == '0)) |=> (gnt == '0));
endmodule

bind dma_bus_arbiter dma_arb_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .burst (burst),
  .gnt   (gnt)
);

// File: tb/tb_dma_bus_arbiter.sv
module tb_dma_bus_arbiter;
  logic       clk;
  logic       rst_n;
  logic [3:0] req;
  logic [3:0] burst;
  logic       mode_rr;
  logic [1:0] prio_sel;
  logic [3:0] gnt;

  int checks = 0;
  int fails  = 0;
  int r1_bad = 0;
  bit done   = 0;

  dma_bus_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req(req), .burst(burst),
    .mode_rr(mode_rr), .prio_sel(prio_sel), .gnt(gnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // {mode_rr, prio_sel, req, expected gnt}, applied from idle in this order
  localparam logic [10:0] VECS [12] = '{
    {1'b1, 2'd0, 4'b1111, 4'b0001},
    {1'b1, 2'd0, 4'b1111, 4'b0010},
    {1'b1, 2'd0, 4'b1111, 4'b0100},
    {1'b1, 2'd0, 4'b1111, 4'b1000},
    {1'b1, 2'd0, 4'b1010, 4'b0010},
    {1'b1, 2'd0, 4'b0011, 4'b0001},
    {1'b0, 2'd0, 4'b1111, 4'b0001},
    {1'b0, 2'd2, 4'b1011, 4'b1000},
    {1'b0, 2'd3, 4'b0110, 4'b0010},
    {1'b0, 2'd1, 4'b1101, 4'b0100},
    {1'b0, 2'd0, 4'b1000, 4'b1000},
    {1'b1, 2'd0, 4'b0101, 4'b0001}
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: gnt=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic settle_idle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk)
    if (rst_n && !$onehot0(gnt)) r1_bad++;

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; burst = '0; mode_rr = 1'b1; prio_sel = '0;
    repeat (3) @(negedge clk);
    check("R2 reset grants low", gnt, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 timing plus R4 / R5 ordering (the first row also covers R2)
    for (int v = 0; v < 12; v++) begin
      mode_rr  = VECS[v][10];
      prio_sel = VECS[v][9:8];
      req      = VECS[v][7:4];
      @(posedge clk);
      @(negedge clk);
      check(VECS[v][10] ? $sformatf("R5 R3 vec %0d", v) : $sformatf("R4 R3 vec %0d", v),
            gnt, VECS[v][3:0]);
      req = '0;
      settle_idle();
    end

    // burst hold (round-robin position is now channel 0, so the search starts at 1)
    mode_rr = 1'b1;
    req = 4'b0100; burst = 4'b0100;
    @(posedge clk);
    @(negedge clk);
    req = 4'b1011;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R6 burst hold", gnt, 4'b0100);
    end
    burst = '0;
    @(negedge clk);
    check("R7 release after burst", gnt, 4'b0000);
    @(negedge clk);
    check("R8 second gap cycle", gnt, 4'b0000);
    @(negedge clk);
    check("R8 R5 grant after gap", gnt, 4'b1000);
    req = '0;
    settle_idle();

    // no request: nothing granted, position held at channel 3
    repeat (5) @(negedge clk);
    check("R9 idle grants low", gnt, 4'b0000);
    req = 4'b1111;
    @(posedge clk);
    @(negedge clk);
    check("R9 position unchanged", gnt, 4'b0001);
    req = '0;
    settle_idle();

    checks++;
    if (r1_bad != 0) begin
      fails++;
      $display("FAIL R1 onehot: bad cycles=%0d expected=0", r1_bad);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule